// File: doc/BRIEF.md
# Byte-Wide Configuration Stream Parser

This block receives a configuration bitstream one byte per clock, qualified by a valid strobe. It skips any run of all-ones fill bytes until a preamble byte appears. It then takes a 24-bit length field, most significant byte first. The length is kept for observation only and never steers the parse. After the length comes a fixed check byte. The stream then carries a fixed number of frames. Each frame has the following parts:

- a start marker byte;
- a fixed count of payload bytes;
- a closing check byte;
- a five-byte write-extension sequence.

After the last frame, a run of all-ones start-up bytes completes the load.

Payload bytes appear on the output with a strobe and a flag on the last byte of each frame. Any byte at a checked position that does not match the value expected there stops the load. The block then raises a sticky error, pulls the active-low init output low and ignores further input. An active-low program input returns the block to its hunting state and clears the error.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset, `init_n` is 1 and `done`, `err` and `out_valid` are 0.
- R2: Before the preamble byte 0xF2 is seen, every accepted byte (0xFF fill or any other value) is discarded: there is no output strobe and no error.
- R3: The three bytes accepted after the preamble are presented on `len_count`, first byte in bits 23:16. The value in them does not change how the rest of the stream is parsed.
- R4: The byte after the length must be 0xD2. Any other value sets the error.
- R5: Each frame must open with 0xFE, or with 0xFF when `ALT_START` is 1. Any other value sets the error.
- R6: The FRAME_BYTES bytes after a start byte are forwarded unchanged, whatever their value. `out_valid` and `out_byte` appear in the cycle after each byte is accepted, and `out_last` is 1 only with the frame's final byte.
- R7: The byte after a frame's payload must be 0xD2. Any other value sets the error.
- R8: After each frame's check byte, the bytes 0xFF, 0xD2, 0xFF, 0xFF, 0xFF must follow in that order. A mismatch sets the error.
- R9: After NUM_FRAMES frames, STARTUP_BYTES bytes of 0xFF raise `done` in the cycle after the last one is accepted, and not before. A non-0xFF byte in this run sets the error. Any bytes after `done` are ignored, and `done` stays high.
- R10: Once the error is set, `err` stays 1 and `init_n` stays 0, and `done` and `out_valid` stay 0, until the program input is pulsed.
- R11: `prog_n` low at a clock edge clears the error, `done`, the length and the output strobe, and restarts the preamble hunt.
- R12: Cycles with `in_valid` low do not advance the parse and produce no output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Synchronous active-low restart that clears the error |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte of a frame |
| len_count | output | 24 | Captured length field |
| done | output | 1 | Load completed |
| err | output | 1 | Sticky check failure |
| init_n | output | 1 | Active-low init, low while in error |

## Verification
The assertions check these rules on every cycle: the error and completion flags are sticky, the restart input clears all state, no strobe appears on an idle input cycle, the last-byte flag never appears without the strobe, and the error excludes both completion and output. Only the bench's scenarios can show the rest. It confirms that each kind of bad marker (header check, start byte, frame check, write extension) is caught at its own position. It confirms that payload bytes equal to marker values pass through untouched. It also confirms that `done` rises on exactly the final required start-up byte, and that the length value has no effect on the parse.

// File: rtl/cfg_parse_pkg.sv
package cfg_parse_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_LEN,
        ST_HCHK,
        ST_START,
        ST_DATA,
        ST_FCHK,
        ST_EXT,
        ST_TAIL,
        ST_DONE,
        ST_FAULT
    } pst_e;

    localparam logic [7:0] BYTE_ONES   = 8'hFF;
    localparam logic [7:0] BYTE_SYNC   = 8'hF2;
    localparam logic [7:0] BYTE_CHECK  = 8'hD2;
    localparam logic [7:0] BYTE_OPEN   = 8'hFE;
    localparam int         LEN_BYTES   = 3;
    localparam int         EXT_BYTES   = 5;
    // position inside the write-extension run that carries the check value
    localparam int         EXT_CHK_POS = 1;

endpackage

// File: rtl/cfg_marker_match.sv
module cfg_marker_match
    import cfg_parse_pkg::*;
#(
    parameter bit ALT_START = 1'b0,
    parameter int IDX_W     = 3
) (
    input  pst_e             state,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_in,
    output logic             match
);

    logic [7:0] open_byte;
    logic [7:0] exp_byte;
    logic       checked;

    generate
        if (ALT_START) begin : g_open_ones
            assign open_byte = BYTE_ONES;
        end else begin : g_open_std
            assign open_byte = BYTE_OPEN;
        end
    endgenerate

    always_comb begin
        exp_byte = BYTE_ONES;
        checked  = 1'b1;
        unique case (state)
            ST_HCHK:  exp_byte = BYTE_CHECK;
            ST_FCHK:  exp_byte = BYTE_CHECK;
            ST_START: exp_byte = open_byte;
            ST_EXT:   exp_byte = (idx == IDX_W'(EXT_CHK_POS)) ? BYTE_CHECK : BYTE_ONES;
            ST_TAIL:  exp_byte = BYTE_ONES;
            default:  checked  = 1'b0;
        endcase
        match = !checked || (byte_in == exp_byte);
    end

endmodule

// File: rtl/cfg_len_capture.sv
module cfg_len_capture #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic [7:0]       byte_in,
    output logic [LEN_W-1:0] len_out
);

    typedef struct packed {
        logic [LEN_W-1:0] len;
    } len_t;

    len_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d.len = '0;
        end else if (shift) begin
            d.len = {q.len[LEN_W-9:0], byte_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign len_out = q.len;

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
    import cfg_parse_pkg::*;
#(
    parameter int FRAME_BYTES   = 16,
    parameter int NUM_FRAMES    = 8,
    parameter int STARTUP_BYTES = 7,
    parameter bit ALT_START     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prog_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        out_valid,
    output logic [7:0]  out_byte,
    output logic        out_last,
    output logic [23:0] len_count,
    output logic        done,
    output logic        err,
    output logic        init_n
);

    localparam int LEN_W   = 8 * LEN_BYTES;
    localparam int MAX_A   = (FRAME_BYTES > STARTUP_BYTES) ? FRAME_BYTES : STARTUP_BYTES;
    localparam int IDX_MAX = (MAX_A > EXT_BYTES) ? MAX_A : EXT_BYTES;
    localparam int IDX_W   = $clog2(IDX_MAX + 1);
    localparam int FRM_W   = $clog2(NUM_FRAMES + 1);

    localparam logic [IDX_W-1:0] LEN_LAST  = IDX_W'(LEN_BYTES - 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(FRAME_BYTES - 1);
    localparam logic [IDX_W-1:0] EXT_LAST  = IDX_W'(EXT_BYTES - 1);
    localparam logic [IDX_W-1:0] TAIL_LAST = IDX_W'(STARTUP_BYTES - 1);
    localparam logic [FRM_W-1:0] FRM_LAST  = FRM_W'(NUM_FRAMES - 1);

    typedef struct packed {
        pst_e             st;
        logic [IDX_W-1:0] idx;
        logic [FRM_W-1:0] frm;
        logic [7:0]       ob;
        logic             ov;
        logic             ol;
        logic             err;
        logic             done;
    } ctl_t;

    ctl_t d, q;
    logic mk_match;
    logic len_clr;
    logic len_shift;

    cfg_marker_match #(
        .ALT_START(ALT_START),
        .IDX_W    (IDX_W)
    ) marker_i (
        .state  (q.st),
        .idx    (q.idx),
        .byte_in(in_byte),
        .match  (mk_match)
    );

    cfg_len_capture #(
        .LEN_W(LEN_W)
    ) len_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (len_clr),
        .shift  (len_shift),
        .byte_in(in_byte),
        .len_out(len_count)
    );

    always_comb begin
        d         = q;
        d.ov      = 1'b0;
        d.ol      = 1'b0;
        len_clr   = 1'b0;
        len_shift = 1'b0;
        if (!prog_n) begin
            d.st    = ST_HUNT;
            d.idx   = '0;
            d.frm   = '0;
            d.ob    = '0;
            d.err   = 1'b0;
            d.done  = 1'b0;
            len_clr = 1'b1;
        end else if (in_valid) begin
            unique case (q.st)
                ST_HUNT: begin
                    if (in_byte == BYTE_SYNC) begin
                        d.st  = ST_LEN;
                        d.idx = '0;
                    end
                end
                ST_LEN: begin
                    len_shift = 1'b1;
                    if (q.idx == LEN_LAST) begin
                        d.st  = ST_HCHK;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_HCHK: begin
                    if (mk_match) begin
                        d.st  = ST_START;
                        d.frm = '0;
                    end else begin
                        d.st  = ST_FAULT;
                        d.err = 1'b1;
                    end
                end
                ST_START: begin
                    if (mk_match) begin
                        d.st  = ST_DATA;
                        d.idx = '0;
                    end else begin
                        d.st  = ST_FAULT;
                        d.err = 1'b1;
                    end
                end
                ST_DATA: begin
                    d.ov = 1'b1;
                    d.ob = in_byte;
                    if (q.idx == DATA_LAST) begin
                        d.ol  = 1'b1;
                        d.st  = ST_FCHK;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_FCHK: begin
                    if (mk_match) begin
                        d.st  = ST_EXT;
                        d.idx = '0;
                    end else begin
                        d.st  = ST_FAULT;
                        d.err = 1'b1;
                    end
                end
                ST_EXT: begin
                    if (!mk_match) begin
                        d.st  = ST_FAULT;
                        d.err = 1'b1;
                    end else if (q.idx == EXT_LAST) begin
                        d.idx = '0;
                        if (q.frm == FRM_LAST) begin
                            d.st = ST_TAIL;
                        end else begin
                            d.st  = ST_START;
                            d.frm = q.frm + 1'b1;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (!mk_match) begin
                        d.st  = ST_FAULT;
                        d.err = 1'b1;
                    end else if (q.idx == TAIL_LAST) begin
                        d.st   = ST_DONE;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_HUNT, idx: '0, frm: '0, ob: '0,
                   ov: 1'b0, ol: 1'b0, err: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ov;
    assign out_byte  = q.ob;
    assign out_last  = q.ol;
    assign done      = q.done;
    assign err       = q.err;
    assign init_n    = ~q.err;

endmodule

// File: rtl/cfg_parser_chk.sv
module cfg_parser_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_n,
    input logic in_valid,
    input logic out_valid,
    input logic out_last,
    input logic done,
    input logic err
);

    // R6
    last_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && prog_n |=> done);

    // R9
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err && prog_n |=> err);

    // R10
    err_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid && !done);

    // R11
    prog_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> !err && !done && !out_valid);

    // R12
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

bind cfg_stream_parser cfg_parser_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_n   (prog_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_last (out_last),
    .done     (done),
    .err      (err)
);

// File: tb/cfg_stream_parser_tb.sv
module cfg_stream_parser_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FB = 4;
    localparam int NF = 2;
    localparam int SB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_n = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_last;
    logic [23:0] len_count;
    logic        done;
    logic        err;
    logic        init_n;

    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;
    logic [8:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_stream_parser #(
        .FRAME_BYTES  (FB),
        .NUM_FRAMES   (NF),
        .STARTUP_BYTES(SB),
        .ALT_START    (1'b0)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_n   (prog_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .out_valid(out_valid),
        .out_byte (out_byte),
        .out_last (out_last),
        .len_count(len_count),
        .done     (done),
        .err      (err),
        .init_n   (init_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every payload strobe is matched against the scoreboard (R6, R10, R12)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R6/R10 unexpected strobe actual=%0h expected=none", {out_last, out_byte});
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({out_last, out_byte} !== e) begin
                    n_err++;
                    $display("FAIL R6 payload actual=%0h expected=%0h", {out_last, out_byte}, e);
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_prog();
        in_valid = 1'b0;
        prog_n   = 1'b0;
        @(negedge clk);
        prog_n   = 1'b1;
    endtask

    task automatic send_head(input logic [23:0] len);
        send(8'hFF);
        send(8'hFF);
        send(8'hF2);
        send(len[23:16]);
        send(len[15:8]);
        send(len[7:0]);
        send(8'hD2);
    endtask

    task automatic send_payload(input logic [7:0] base, input bit gaps);
        for (int k = 0; k < FB; k++) begin
            logic [7:0] v;
            v = base + 8'(k);
            exp_q.push_back({(k == FB - 1), v});
            send(v);
            if (gaps) idle(2);
        end
    endtask

    task automatic send_ext();
        send(8'hFF);
        send(8'hD2);
        send(8'hFF);
        send(8'hFF);
        send(8'hFF);
    endtask

    task automatic send_frame(input logic [7:0] base, input bit gaps);
        send(8'hFE);
        send_payload(base, gaps);
        send(8'hD2);
        send_ext();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 init_n", init_n, 1);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 out_valid", out_valid, 0);

        // R2 fill and junk before preamble are discarded
        send(8'hFF);
        send(8'h55);
        send(8'hD2);
        idle(1);
        chk("R2 no error in hunt", err, 0);

        // full good stream, gaps inside frame 0 (R12)
        send_head(24'h123456);
        chk("R3 length captured", len_count, 32'h123456);
        send_frame(8'hFE, 1'b1);
        send_frame(8'hD0, 1'b0);
        send(8'hFF);
        send(8'hFF);
        chk("R9 done not early", done, 0);
        send(8'hFF);
        chk("R9 done after tail", done, 1);
        chk("R9 no error", err, 0);
        send(8'h00);
        send(8'hFF);
        idle(2);
        chk("R9 extra bytes ignored", done, 1);
        chk("R6 all payload seen", exp_q.size(), 0);

        // R11 restart clears
        pulse_prog();
        chk("R11 done cleared", done, 0);
        chk("R11 len cleared", len_count, 0);

        // R3 different length, same parse
        send_head(24'hABCDEF);
        chk("R3 second length", len_count, 32'hABCDEF);
        send_frame(8'h10, 1'b0);
        send_frame(8'h20, 1'b0);
        repeat (SB) send(8'hFF);
        chk("R3 length ignored for control", done, 1);
        pulse_prog();

        // R4 bad header check
        send_head(24'h000001);
        idle(1);
        pulse_prog();
        send(8'hF2); send(8'h00); send(8'h00); send(8'h01);
        send(8'hD3);
        chk("R4 err", err, 1);
        chk("R10 init_n low", init_n, 0);
        send(8'hFE); send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        idle(2);
        chk("R10 err stays", err, 1);
        chk("R10 no done", done, 0);
        pulse_prog();
        chk("R11 err cleared", err, 0);
        chk("R11 init_n high", init_n, 1);

        // R5 bad start byte (0xFF with standard opening)
        send_head(24'h000002);
        send(8'hFF);
        chk("R5 err", err, 1);
        pulse_prog();

        // R7 bad frame check, payload still forwarded
        send_head(24'h000003);
        send(8'hFE);
        send_payload(8'h40, 1'b0);
        send(8'h00);
        chk("R7 err", err, 1);
        chk("R7 payload drained", exp_q.size(), 0);
        pulse_prog();

        // R8 bad write-extension
        send_head(24'h000004);
        send(8'hFE);
        send_payload(8'h60, 1'b0);
        send(8'hD2);
        send(8'hFF);
        chk("R8 no err before bad byte", err, 0);
        send(8'hFF);
        chk("R8 err", err, 1);
        pulse_prog();

        // R9 non-ones in start-up tail
        send_head(24'h000005);
        send_frame(8'h70, 1'b0);
        send_frame(8'h80, 1'b0);
        send(8'hFF);
        send(8'h7F);
        chk("R9 bad tail err", err, 1);
        chk("R9 bad tail no done", done, 0);
        idle(2);
        chk("R6 scoreboard empty", exp_q.size(), 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule